// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel data word into an NRZ serial frame on a single output line. Software-facing logic writes a word into a holding register. At the next bit-clock tick the word moves into a shift register, and a frame goes out: a low start bit, then 5 to 8 data bits with the least significant bit first, an optional parity bit, and a stop period at mark level. Bit timing comes from an external enable that pulses once per sixteenth of a bit. Each bit lasts 16 of those ticks.

Static inputs set the frame format: word length, parity kind and the stop-bit rule. The block latches them when a character starts. A 2-bit transmit-control field drives the request-to-send output and gates the transmit interrupt. Its fourth value sends continuous break characters. An active-low clear-to-send input holds the line at mark at character boundaries. An echo select makes the output repeat the serial receive input, delayed by half a bit time.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, txd is 1 (mark), hold_empty is 1 and tx_irq is 0. rts_n is 1 while tx_ctl is 00 and echo_en is 0.
- R2: Data bits go out least significant bit first. The count comes from wlen_sel: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. Holding-register bits above the selected count never reach txd.
- R3: When par_en is 1, one parity bit follows the data. par_mode selects it: 00 gives odd (the ones in data plus parity are odd), 01 gives even, 10 gives a constant 1 and 11 gives a constant 0. When par_en is 0, no parity bit is sent.
- R4: With stop_sel at 0, the stop period lasts 16 ticks. With stop_sel at 1, it lasts 24 ticks for a 5-bit word without parity, 16 ticks for an 8-bit word with parity, and 32 ticks otherwise.
- R5: A write to the holding register clears hold_empty on the next cycle. hold_empty sets only on the tick edge where the stored word moves into the shift register, which is the edge where the start bit begins.
- R6: Each bit lasts 16 ticks. Without new data, txd idles at 1. A write to an idle transmitter starts a start bit on the next tick. A word written before the stop period ends follows with no idle gap.
- R7: rts_n is 1 only for tx_ctl 00 (outside echo mode). tx_irq is 1 exactly when hold_empty is 1, tx_ctl is 01 and echo_en is 0.
- R8: tx_ctl 11 sends break characters from the next character boundary. A break character holds txd at 0 for a full character length and leaves the holding register untouched. A break character that has begun always finishes. On leaving break mode, one stop period at mark follows, and then normal transmission resumes.
- R9: With cts_n at 1, no new character starts. A character already in flight finishes, including parity and stop. A word waiting in the holding register stays there, so hold_empty stays 0 and tx_irq stays 0.
- R10: With echo_en at 1, txd equals the rxd level sampled 8 ticks earlier and rts_n is 0. No new character starts, so a waiting word is kept for later.
- R11: Word length, parity and stop settings are captured when a character starts. Changes made while the character is in flight take effect only on the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse, 16 per bit time |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_din | input | 8 | Word to transmit |
| wlen_sel | input | 2 | Word length: 00=8, 01=7, 10=6, 11=5 |
| par_en | input | 1 | Parity bit enable |
| par_mode | input | 2 | Parity kind: 00 odd, 01 even, 10 one, 11 zero |
| stop_sel | input | 1 | Stop-bit rule select |
| tx_ctl | input | 2 | Request-to-send, interrupt and break control |
| echo_en | input | 1 | Resend rxd on txd with a half-bit delay |
| cts_n | input | 1 | Clear to send, active low |
| rxd | input | 1 | Serial receive line, used for echo |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request to send, active low |
| hold_empty | output | 1 | Holding register empty |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The assertions check the following on every cycle:
- a write fills the holding register;
- the empty flag rises only as a start bit begins;
- an idle transmitter with clear-to-send inactive stays idle;
- a break character never consumes the holding register;
- the data-bit index and the stop counter stay within the latched frame.

Only the bench's scenarios can show the exact serial waveform. That covers bit order, parity values, the three stop lengths, back-to-back frames, the stop period after a break, and the half-bit echo delay. The bench compares each one against a behavioural model on every clock.

// File: rtl/aftx_pkg.sv
package aftx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   typedef enum logic [1:0] {
      PM_ODD   = 2'b00,
      PM_EVEN  = 2'b01,
      PM_MARK  = 2'b10,
      PM_SPACE = 2'b11
   } par_mode_e;

   typedef enum logic [1:0] {
      TC_RTS_OFF = 2'b00,
      TC_IRQ_ON  = 2'b01,
      TC_QUIET   = 2'b10,
      TC_BREAK   = 2'b11
   } tx_ctl_e;
endpackage

// File: rtl/aftx_frame_cfg.sv
module aftx_frame_cfg
   import aftx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        wlen_sel,
   input  logic              par_en,
   input  logic [1:0]        par_mode,
   input  logic              stop_sel,
   output logic [$clog2(DATA_W+1)-1:0] nbits,
   output logic [$clog2(2*OVS+1)-1:0]  stop_ticks,
   output logic              par_bit
);
   localparam int IDX_W = $clog2(DATA_W+1);
   localparam int STW   = $clog2(2*OVS+1);
   localparam logic [STW-1:0] T_ONE  = STW'(OVS);
   localparam logic [STW-1:0] T_HALF = STW'(OVS + OVS/2);
   localparam logic [STW-1:0] T_TWO  = STW'(2*OVS);

   logic [DATA_W-1:0] d_m;
   logic              ones_odd;

   assign nbits = IDX_W'(DATA_W) - IDX_W'(wlen_sel);

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         d_m[i] = data[i] & (i < int'(nbits));
      end
   end

   assign ones_odd = ^d_m;

   always_comb begin
      case (par_mode_e'(par_mode))
         PM_ODD:   par_bit = ~ones_odd;
         PM_EVEN:  par_bit = ones_odd;
         PM_MARK:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end

   always_comb begin
      if (!stop_sel)                          stop_ticks = T_ONE;
      else if (wlen_sel == 2'b11 && !par_en)  stop_ticks = T_HALF;
      else if (wlen_sel == 2'b00 && par_en)   stop_ticks = T_ONE;
      else                                    stop_ticks = T_TWO;
   end
endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter
   import aftx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_din,
   input  logic              cts_n,
   input  logic              inhibit,
   input  logic              brk_mode,
   input  logic [$clog2(DATA_W+1)-1:0] cfg_nbits,
   input  logic [$clog2(2*OVS+1)-1:0]  cfg_stop,
   input  logic              cfg_par_en,
   input  logic              cfg_par_bit,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_empty,
   output logic              txd_sh
);
   localparam int IDX_W = $clog2(DATA_W+1);
   localparam int STW   = $clog2(2*OVS+1);
   localparam logic [STW-1:0] BIT_LAST = STW'(OVS-1);

   tx_state_e         state;
   logic [STW-1:0]    sub;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] sh;
   logic [IDX_W-1:0]  nb_l;
   logic [STW-1:0]    stop_l;
   logic              pe_l, pb_l, brk_l, full;
   logic              char_end, decide, go_post, go_brk, go_data, may_start;

   assign char_end  = (state == ST_STOP) && (sub == stop_l - STW'(1));
   assign decide    = tick && ((state == ST_IDLE) || char_end);
   assign go_post   = decide && (state == ST_STOP) && brk_l && !brk_mode;
   assign may_start = decide && !go_post && !cts_n && !inhibit;
   assign go_brk    = may_start && brk_mode;
   assign go_data   = may_start && !brk_mode && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sub    <= '0;
         idx    <= '0;
         sh     <= '0;
         nb_l   <= '0;
         stop_l <= STW'(OVS);
         pe_l   <= 1'b0;
         pb_l   <= 1'b0;
         brk_l  <= 1'b0;
         full   <= 1'b0;
         hold_q <= '0;
      end else begin
         if (hold_wr) hold_q <= hold_din;
         if (hold_wr)      full <= 1'b1;
         else if (go_data) full <= 1'b0;
         if (tick) begin
            if (go_post) begin
               state <= ST_STOP;
               sub   <= '0;
               brk_l <= 1'b0;
            end else if (go_brk || go_data) begin
               state  <= ST_START;
               sub    <= '0;
               brk_l  <= go_brk;
               nb_l   <= cfg_nbits;
               stop_l <= cfg_stop;
               pe_l   <= cfg_par_en;
               pb_l   <= cfg_par_bit;
               sh     <= hold_q;
            end else if (decide) begin
               state <= ST_IDLE;
               sub   <= '0;
               brk_l <= 1'b0;
            end else if (state != ST_IDLE) begin
               if (sub == BIT_LAST && state != ST_STOP) begin
                  sub <= '0;
                  case (state)
                     ST_START: begin
                        state <= ST_DATA;
                        idx   <= '0;
                     end
                     ST_DATA: begin
                        sh  <= sh >> 1;
                        idx <= idx + IDX_W'(1);
                        if (idx == nb_l - IDX_W'(1))
                           state <= pe_l ? ST_PAR : ST_STOP;
                     end
                     default: state <= ST_STOP;
                  endcase
               end else begin
                  sub <= sub + STW'(1);
               end
            end
         end
      end
   end

   assign hold_empty = ~full;

   always_comb begin
      if (state == ST_IDLE) txd_sh = 1'b1;
      else if (brk_l)       txd_sh = 1'b0;
      else begin
         case (state)
            ST_START: txd_sh = 1'b0;
            ST_DATA:  txd_sh = sh[0];
            ST_PAR:   txd_sh = pb_l;
            default:  txd_sh = 1'b1;
         endcase
      end
   end

   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> !hold_empty); // R5
   AST_EMPTY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> (state == ST_START)); // R5
   AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && cts_n) |=> (state == ST_IDLE)); // R9
   AST_BRK_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      go_brk |=> (full == ($past(full) | $past(hold_wr)))); // R8
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |-> (idx < nb_l)); // R2
   AST_STOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP) |-> (sub < stop_l)); // R4
endmodule

// File: rtl/aftx_echo_line.sv
module aftx_echo_line #(
   parameter int HALF = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rxd,
   output logic echo_out
);
   logic [HALF:0] dl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dl <= '1;
      else if (tick) dl <= {dl[HALF-1:0], rxd};
   end

   assign echo_out = dl[HALF];
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
   import aftx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int OVS     = 16,
   parameter bit ECHO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              hold_wr,
   input  logic [DATA_W-1:0] hold_din,
   input  logic [1:0]        wlen_sel,
   input  logic              par_en,
   input  logic [1:0]        par_mode,
   input  logic              stop_sel,
   input  logic [1:0]        tx_ctl,
   input  logic              echo_en,
   input  logic              cts_n,
   input  logic              rxd,
   output logic              txd,
   output logic              rts_n,
   output logic              hold_empty,
   output logic              tx_irq
);
   localparam int IDX_W = $clog2(DATA_W+1);
   localparam int STW   = $clog2(2*OVS+1);
   localparam int HALF  = OVS / 2;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("async_frame_tx: DATA_W must be at least 4");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("async_frame_tx: OVS must be even and at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q;
   logic [IDX_W-1:0]  cfg_nbits;
   logic [STW-1:0]    cfg_stop;
   logic              cfg_par_bit, txd_sh, echo_out, echo_sel, brk_mode;

   assign brk_mode = (tx_ctl == TC_BREAK);

   aftx_frame_cfg #(.DATA_W(DATA_W), .OVS(OVS)) u_cfg (
      .data       (hold_q),
      .wlen_sel   (wlen_sel),
      .par_en     (par_en),
      .par_mode   (par_mode),
      .stop_sel   (stop_sel),
      .nbits      (cfg_nbits),
      .stop_ticks (cfg_stop),
      .par_bit    (cfg_par_bit)
   );

   aftx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .hold_wr     (hold_wr),
      .hold_din    (hold_din),
      .cts_n       (cts_n),
      .inhibit     (echo_sel),
      .brk_mode    (brk_mode),
      .cfg_nbits   (cfg_nbits),
      .cfg_stop    (cfg_stop),
      .cfg_par_en  (par_en),
      .cfg_par_bit (cfg_par_bit),
      .hold_q      (hold_q),
      .hold_empty  (hold_empty),
      .txd_sh      (txd_sh)
   );

   generate
      if (ECHO_EN) begin : g_echo
         aftx_echo_line #(.HALF(HALF)) u_echo (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick16),
            .rxd      (rxd),
            .echo_out (echo_out)
         );
         assign echo_sel = echo_en;
      end else begin : g_no_echo
         assign echo_out = 1'b1;
         assign echo_sel = 1'b0;
      end
   endgenerate

   assign txd    = echo_sel ? echo_out : txd_sh;
   assign rts_n  = !echo_sel && (tx_ctl == TC_RTS_OFF);
   assign tx_irq = hold_empty && (tx_ctl == TC_IRQ_ON) && !echo_sel;
endmodule

// File: tb/tb_async_frame_tx.sv
module tb_async_frame_tx;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       hold_wr = 1'b0;
   logic [7:0] hold_din = 8'h00;
   logic [1:0] wlen_sel = 2'b00;
   logic       par_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic       stop_sel = 1'b0;
   logic [1:0] tx_ctl = 2'b00;
   logic       echo_en = 1'b0;
   logic       cts_n = 1'b0;
   logic       rxd = 1'b1;
   logic       txd, rts_n, hold_empty, tx_irq;

   int    ncmp = 0;
   int    nbad = 0;
   bit    done = 0;
   string cur_req = "R1";

   async_frame_tx dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .hold_wr(hold_wr),
      .hold_din(hold_din), .wlen_sel(wlen_sel), .par_en(par_en),
      .par_mode(par_mode), .stop_sel(stop_sel), .tx_ctl(tx_ctl),
      .echo_en(echo_en), .cts_n(cts_n), .rxd(rxd), .txd(txd),
      .rts_n(rts_n), .hold_empty(hold_empty), .tx_irq(tx_irq)
   );

   always #(CLK_P/2) clk = ~clk;

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc++;
         tick16 = (tc % 2 == 0);
      end
   end

   // Behavioural reference: per-tick level queue
   bit         q[$];
   bit         hist[$];
   bit         cur = 1'b1;
   bit         full_m = 1'b0;
   logic [7:0] hold_m = 8'h00;
   bit         last_brk = 1'b0;
   int         last_stop = 16;

   function automatic void push_n(bit v, int n);
      for (int k = 0; k < n; k++) q.push_back(v);
   endfunction

   function automatic void push_char(bit brk, logic [7:0] d);
      int nb = 8 - int'(wlen_sel);
      int ones = 0;
      int st;
      bit pb;
      push_n(1'b0, 16);
      for (int i = 0; i < nb; i++) begin
         push_n(brk ? 1'b0 : d[i], 16);
         if (d[i]) ones++;
      end
      if (par_en) begin
         case (par_mode)
            2'b00:   pb = (ones % 2 == 0);
            2'b01:   pb = (ones % 2 == 1);
            2'b10:   pb = 1'b1;
            default: pb = 1'b0;
         endcase
         push_n(brk ? 1'b0 : pb, 16);
      end
      if (!stop_sel)               st = 16;
      else if (nb == 5 && !par_en) st = 24;
      else if (nb == 8 && par_en)  st = 16;
      else                         st = 32;
      push_n(brk ? 1'b0 : 1'b1, st);
      last_stop = st;
   endfunction

   task automatic chk(string what, logic got, logic exp);
      ncmp++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s %s got %b exp %b at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         hist.delete();
         for (int k = 0; k < 9; k++) hist.push_back(1'b1);
         cur = 1'b1; full_m = 1'b0; hold_m = 8'h00; last_brk = 1'b0;
      end else begin
         if (tick16) begin
            hist.push_front(rxd);
            if (hist.size() > 9) void'(hist.pop_back());
            if (q.size() == 0) begin
               if (last_brk && tx_ctl != 2'b11) begin
                  push_n(1'b1, last_stop);
                  last_brk = 1'b0;
               end else if (cts_n || echo_en) begin
                  last_brk = 1'b0;
               end else if (tx_ctl == 2'b11) begin
                  push_char(1'b1, hold_m);
                  last_brk = 1'b1;
               end else if (full_m) begin
                  push_char(1'b0, hold_m);
                  full_m = 1'b0;
                  last_brk = 1'b0;
               end else begin
                  last_brk = 1'b0;
               end
            end
            if (q.size() > 0) cur = q.pop_front();
            else              cur = 1'b1;
         end
         if (hold_wr) begin
            full_m = 1'b1;
            hold_m = hold_din;
         end
      end
      #(CLK_P/4);
      if (rst_n && !done) begin
         chk("txd", txd, echo_en ? hist[8] : cur);
         chk("hold_empty", hold_empty, !full_m);
         chk("rts_n", rts_n, !echo_en && tx_ctl == 2'b00);
         chk("tx_irq", tx_irq, !full_m && tx_ctl == 2'b01 && !echo_en);
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_byte(logic [7:0] d);
      @(negedge clk);
      hold_wr = 1'b1;
      hold_din = d;
      @(negedge clk);
      hold_wr = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         ncmp++;
         nbad++;
         $display("FAIL watchdog %s got hung exp finished", cur_req);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      run(4);
      cur_req = "R1";
      chk("txd", txd, 1'b1);
      chk("hold_empty", hold_empty, 1'b1);
      chk("rts_n", rts_n, 1'b1);
      chk("tx_irq", tx_irq, 1'b0);
      rst_n = 1'b1;
      run(20);

      // R2: word lengths, LSB first, upper bits ignored
      cur_req = "R2";
      tx_ctl = 2'b01;
      wr_byte(8'hA5); run(400);
      wlen_sel = 2'b11; wr_byte(8'hE5); run(300);
      wlen_sel = 2'b10; wr_byte(8'hD3); run(300);
      wlen_sel = 2'b01; wr_byte(8'hB6); run(350);

      // R3: parity kinds
      cur_req = "R3";
      par_en = 1'b1; wlen_sel = 2'b00;
      par_mode = 2'b00; wr_byte(8'h37); run(420);
      par_mode = 2'b01; wr_byte(8'h37); run(420);
      par_mode = 2'b10; wr_byte(8'h00); run(420);
      par_mode = 2'b11; wr_byte(8'hFF); run(420);

      // R4: stop-bit rule
      cur_req = "R4";
      stop_sel = 1'b1;
      par_en = 1'b0; wlen_sel = 2'b11; wr_byte(8'h15); run(320);
      par_en = 1'b1; wlen_sel = 2'b00; wr_byte(8'h81); run(420);
      par_en = 1'b0; wlen_sel = 2'b10; wr_byte(8'h2A); run(380);
      par_en = 1'b1; wlen_sel = 2'b11; wr_byte(8'h0E); run(380);
      stop_sel = 1'b0; par_en = 1'b0; wlen_sel = 2'b00;

      // R5 R6: empty flag, idle mark, back-to-back frames
      cur_req = "R5";
      wr_byte(8'h3C); run(10); wr_byte(8'hC3); run(40);
      cur_req = "R6";
      wr_byte(8'h99); run(900);
      wr_byte(8'h01); run(600);

      // R7: control field on rts_n and tx_irq
      cur_req = "R7";
      tx_ctl = 2'b00; wr_byte(8'h5A); run(80);
      tx_ctl = 2'b10; run(80);
      tx_ctl = 2'b01; run(300);

      // R8: break mode, sustained and brief
      cur_req = "R8";
      tx_ctl = 2'b11; run(600);
      wr_byte(8'h77);
      tx_ctl = 2'b01; run(800);
      tx_ctl = 2'b11; run(4); tx_ctl = 2'b10; run(800);

      // R9: clear-to-send gating
      cur_req = "R9";
      tx_ctl = 2'b01;
      wr_byte(8'hF0); run(40); wr_byte(8'h0F); run(60);
      cts_n = 1'b1; run(700);
      cts_n = 1'b0; run(450);

      // R10: echo mode
      cur_req = "R10";
      echo_en = 1'b1; wr_byte(8'h6D);
      for (int k = 0; k < 60; k++) begin
         rxd = ((k * 7) % 5) < 2;
         run(7 + (k % 4) * 5);
      end
      rxd = 1'b1; run(40);
      echo_en = 1'b0; run(450);

      // R11: settings latched at character start
      cur_req = "R11";
      wr_byte(8'hC9); run(60);
      wlen_sel = 2'b11; par_en = 1'b1; stop_sel = 1'b1; run(400);
      wr_byte(8'hC9); run(400);

      done = 1;
      summary();
      $finish;
   end
endmodule